// File: doc/BRIEF.md
# Dual-Source Instruction Fetch Unit

This unit is the fetch front end of a small 32-bit core whose 512-word local memory serves both as its register file and as code store, and which also shares a larger memory with other cores through a time-sliced access slot. A widened program counter picks the source. Addresses below 512 are read from local memory with one cycle of latency. Higher addresses are read from the shared memory at the same word number, but only in the cycle the slot strobe marks as this core's turn. Fetch latency therefore depends on where the program counter points.

The execute stage receives one instruction word per valid cycle, together with the address it came from, and a stall flag that marks cycles lost to waiting for the shared slot. Execute can redirect fetch with one of three jump forms. A near jump keeps the upper address bits. A banked jump takes its upper bits from a bank register. A long jump joins two 9-bit operand fields into one 18-bit target. A redirect cancels any fetch that would have been issued in the same cycle, and that includes a shared fetch that was still waiting for its slot.

Top module: `fetch_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, `insnValid` and `insnStall` are 0. The first cycle after release requests local word 0, and the bank register is 0.
- R2: With no jump and a program counter P below 512, `localRe` is 1 and `localAddr` is P. In the next cycle `insnValid` is 1, `insnPc` is P and `insnWord` is the local memory word at P. A run of local code delivers one instruction per cycle.
- R3: With no jump and P at 512 or above, `sharedRe` is 1 with `sharedAddr` equal to P only in a cycle where `slotStb` is 1. The word read from shared memory is delivered in the cycle after that strobe, with `insnPc` equal to P.
- R4: When P is at 512 or above and `slotStb` is 0 with no jump, the next cycle shows `insnStall`=1 and `insnValid`=0, and P does not change.
- R5: Each issued fetch advances the program counter by exactly one word. Address 511 is followed by 512, which is shared space. The top address, all ones, wraps to 0, which is local space.
- R6: A near jump (`jmpKind`=2'b00) sets the program counter to {upper bits of the address of the most recently issued fetch, `jmpDst`}.
- R7: A banked jump (`jmpKind`=2'b01) sets the program counter to {bank register, `jmpDst`}. `bankWe` loads `bankIn` at the clock edge. A banked jump in the same cycle still uses the old bank value, and the bank register holds its value whenever `bankWe` is 0.
- R8: A long jump (`jmpKind`=2'b10 or 2'b11) sets the program counter to {`jmpSrc`, `jmpDst`}, with `jmpSrc` as the upper 9 bits.
- R9: In a cycle with `jmpValid`=1, neither memory is requested. The next cycle shows `insnValid`=0 and `insnStall`=0, and that cycle fetches the jump target.
- R10: A jump that arrives in the cycle where a waiting shared fetch would meet its strobe cancels that fetch. `sharedRe` stays 0, and no instruction for the old address is ever delivered.
- R11: A shared request never carries an address below 512, so shared words 0 to 511 are never fetched as code.
- R12: `localRe` and `sharedRe` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotStb | input | 1 | One-cycle strobe marking this core's shared-memory access window |
| jmpValid | input | 1 | Redirect request from execute |
| jmpKind | input | 2 | Jump form: 00 near, 01 banked, 10/11 long |
| jmpSrc | input | 9 | Upper 9 bits of a long-jump target |
| jmpDst | input | 9 | Low 9 bits of any jump target |
| bankWe | input | 1 | Load the bank register |
| bankIn | input | PC_W-9 (9) | New bank value |
| localRe | output | 1 | Local memory read request |
| localAddr | output | 9 | Local memory word address |
| localRdata | input | 32 | Local memory read data, registered one cycle after the request |
| sharedRe | output | 1 | Shared memory read request, issued in the slot cycle |
| sharedAddr | output | PC_W (18) | Shared memory word address |
| sharedRdata | input | 32 | Shared memory read data, one cycle after the request |
| insnValid | output | 1 | Instruction word valid this cycle |
| insnStall | output | 1 | No instruction this cycle because fetch waited for the slot |
| insnWord | output | 32 | Instruction word, 0 when not valid |
| insnPc | output | PC_W (18) | Address of the delivered instruction |

## Verification
The bench builds the unit with an 18-bit program counter and an 8-cycle access window, and places strobes at a fixed phase inside that window. The shorter window keeps slot waits short, so long stretches of shared-space execution fit in a short run. The 18-bit counter means a long jump can reach the very top address, and the wrap from there back into local space can be observed. Because the bench knows the strobe phase, it can also place a jump exactly on a strobe cycle, which cancels a waiting shared fetch.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [1:0] {
    JMP_NEAR     = 2'b00,
    JMP_BANK     = 2'b01,
    JMP_LONG     = 2'b10,
    JMP_LONG_ALT = 2'b11
  } jmp_kind_e;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic issueLocal;   // local read requested this cycle
    logic issueShared;  // shared read requested this cycle
    logic redirect;     // load the jump target
    logic advance;      // a fetch was issued, step the PC
    logic waitSlot;     // shared fetch held back for the slot
  } fetch_ctl_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
#(
  parameter int SLOT_PERIOD = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pcShared,
  input  logic       slotStb,
  input  logic       jmpValid,
  output fetch_ctl_t ctl
);

  localparam int GAP_W = $clog2(SLOT_PERIOD + 1);

  always_comb begin
    ctl.redirect    = jmpValid;
    ctl.issueLocal  = !jmpValid && !pcShared;
    ctl.issueShared = !jmpValid && pcShared && slotStb;
    ctl.waitSlot    = !jmpValid && pcShared && !slotStb;
    ctl.advance     = ctl.issueLocal || ctl.issueShared;
  end

  // Cycles since the last strobe, saturating at the window length
  logic [GAP_W-1:0] gapCnt;
  logic             seenSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt   <= '0;
      seenSlot <= 1'b0;
    end else if (slotStb) begin
      gapCnt   <= '0;
      seenSlot <= 1'b1;
    end else if (gapCnt != GAP_W'(SLOT_PERIOD)) begin
      gapCnt   <= gapCnt + 1'b1;
    end
  end

  // R3: shared requests come no more often than once per window
  slot_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotStb && seenSlot) |-> (gapCnt >= GAP_W'(SLOT_PERIOD - 1)));

  // R4: a held shared fetch keeps the PC in shared space
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.waitSlot |=> pcShared);

endmodule

// File: rtl/fetch_dp.sv
module fetch_dp
  import fetch_pkg::*;
#(
  parameter int PC_W     = 18,
  parameter int LOCAL_AW = 9,
  parameter int DATA_W   = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fetch_ctl_t               ctl,
  input  logic [1:0]               jmpKind,
  input  logic [LOCAL_AW-1:0]      jmpSrc,
  input  logic [LOCAL_AW-1:0]      jmpDst,
  input  logic                     bankWe,
  input  logic [PC_W-LOCAL_AW-1:0] bankIn,
  input  logic [DATA_W-1:0]        localRdata,
  input  logic [DATA_W-1:0]        sharedRdata,
  output logic                     pcShared,
  output logic [LOCAL_AW-1:0]      localAddr,
  output logic [PC_W-1:0]          sharedAddr,
  output logic                     insnValid,
  output logic                     insnStall,
  output logic [DATA_W-1:0]        insnWord,
  output logic [PC_W-1:0]          insnPc
);

  localparam int BANK_W      = PC_W - LOCAL_AW;
  localparam int LOCAL_WORDS = 1 << LOCAL_AW;

  logic [PC_W-1:0]   pcQ;
  logic [BANK_W-1:0] bankQ;
  logic [PC_W-1:0]   insnPcQ;
  logic              validQ;
  logic              stallQ;
  logic              selSharedQ;
  logic [PC_W-1:0]   jmpTgt;

  assign pcShared   = |pcQ[PC_W-1:LOCAL_AW];
  assign localAddr  = pcQ[LOCAL_AW-1:0];
  assign sharedAddr = pcQ;

  // Jump target formation
  always_comb begin
    case (jmp_kind_e'(jmpKind))
      JMP_NEAR: jmpTgt = {insnPcQ[PC_W-1:LOCAL_AW], jmpDst};
      JMP_BANK: jmpTgt = {bankQ, jmpDst};
      default:  jmpTgt = PC_W'({jmpSrc, jmpDst});
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ        <= '0;
      bankQ      <= '0;
      insnPcQ    <= '0;
      validQ     <= 1'b0;
      stallQ     <= 1'b0;
      selSharedQ <= 1'b0;
    end else begin
      if (ctl.redirect)     pcQ <= jmpTgt;
      else if (ctl.advance) pcQ <= pcQ + 1'b1;
      if (ctl.advance)      insnPcQ <= pcQ;
      if (bankWe)           bankQ <= bankIn;
      validQ     <= ctl.advance;
      stallQ     <= ctl.waitSlot;
      selSharedQ <= ctl.issueShared;
    end
  end

  assign insnValid = validQ;
  assign insnStall = stallQ;
  assign insnPc    = insnPcQ;
  assign insnWord  = !validQ    ? '0 :
                     selSharedQ ? sharedRdata : localRdata;

  // R2
  local_deliver_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueLocal |=> (insnValid && !selSharedQ && insnPc == $past(pcQ)));

  // R3
  shared_deliver_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueShared |=> (insnValid && selSharedQ && insnPc == $past(pcQ)));

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (pcQ == PC_W'($past(pcQ) + 1'b1)));

  // R9
  redirect_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.redirect |=> (!insnValid && !insnStall));

  // R4
  stall_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    insnStall |-> !insnValid);

  // R11
  shared_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issueShared |-> (sharedAddr >= PC_W'(LOCAL_WORDS)));

  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bankWe |=> $stable(bankQ));

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int PC_W        = 18,
  parameter int LOCAL_AW    = 9,
  parameter int DATA_W      = 32,
  parameter int SLOT_PERIOD = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     slotStb,
  input  logic                     jmpValid,
  input  logic [1:0]               jmpKind,
  input  logic [LOCAL_AW-1:0]      jmpSrc,
  input  logic [LOCAL_AW-1:0]      jmpDst,
  input  logic                     bankWe,
  input  logic [PC_W-LOCAL_AW-1:0] bankIn,
  output logic                     localRe,
  output logic [LOCAL_AW-1:0]      localAddr,
  input  logic [DATA_W-1:0]        localRdata,
  output logic                     sharedRe,
  output logic [PC_W-1:0]          sharedAddr,
  input  logic [DATA_W-1:0]        sharedRdata,
  output logic                     insnValid,
  output logic                     insnStall,
  output logic [DATA_W-1:0]        insnWord,
  output logic [PC_W-1:0]          insnPc
);

  fetch_ctl_t ctl;
  logic       pcShared;

  fetch_ctrl #(.SLOT_PERIOD(SLOT_PERIOD)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pcShared (pcShared),
    .slotStb  (slotStb),
    .jmpValid (jmpValid),
    .ctl      (ctl)
  );

  fetch_dp #(.PC_W(PC_W), .LOCAL_AW(LOCAL_AW), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .jmpKind     (jmpKind),
    .jmpSrc      (jmpSrc),
    .jmpDst      (jmpDst),
    .bankWe      (bankWe),
    .bankIn      (bankIn),
    .localRdata  (localRdata),
    .sharedRdata (sharedRdata),
    .pcShared    (pcShared),
    .localAddr   (localAddr),
    .sharedAddr  (sharedAddr),
    .insnValid   (insnValid),
    .insnStall   (insnStall),
    .insnWord    (insnWord),
    .insnPc      (insnPc)
  );

  assign localRe  = ctl.issueLocal;
  assign sharedRe = ctl.issueShared;

  // R12
  one_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(localRe && sharedRe));

endmodule

// File: tb/sim_fetch_unit.sv
module sim_fetch_unit;

  localparam int PC_W        = 18;
  localparam int SLOT_PERIOD = 8;
  localparam int PHASE       = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              slotStb = 1'b0;
  logic              jv = 1'b0;
  logic [1:0]        jk = 2'b00;
  logic [8:0]        js = '0, jd = '0;
  logic              bw = 1'b0;
  logic [8:0]        bi = '0;
  logic              localRe, sharedRe, insnValid, insnStall;
  logic [8:0]        localAddr;
  logic [PC_W-1:0]   sharedAddr, insnPc;
  logic [31:0]       localRdata = '0, sharedRdata = '0, insnWord;

  int chkCnt = 0;
  int failCnt = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  fetch_unit #(.PC_W(PC_W), .LOCAL_AW(9), .DATA_W(32), .SLOT_PERIOD(SLOT_PERIOD)) u0 (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .jmpValid(jv), .jmpKind(jk),
    .jmpSrc(js), .jmpDst(jd), .bankWe(bw), .bankIn(bi),
    .localRe(localRe), .localAddr(localAddr), .localRdata(localRdata),
    .sharedRe(sharedRe), .sharedAddr(sharedAddr), .sharedRdata(sharedRdata),
    .insnValid(insnValid), .insnStall(insnStall), .insnWord(insnWord), .insnPc(insnPc)
  );

  function automatic logic [31:0] locWord(input logic [8:0] a);
    return 32'hA500_0000 ^ (32'(a) * 32'h0000_9E37);
  endfunction

  function automatic logic [31:0] shWord(input logic [PC_W-1:0] a);
    return 32'h5A00_0000 ^ (32'(a) * 32'h2545_F491);
  endfunction

  // Memory models: one-cycle registered read
  always @(posedge clk) begin
    if (localRe)  localRdata  <= locWord(localAddr);
    if (sharedRe) sharedRdata <= shWord(sharedAddr);
  end

  // Behavioural reference model
  logic [PC_W-1:0] mPc = '0, mOutPc = '0, mBank = '0;
  logic [31:0]     mWord = '0;
  bit              mValid = 0, mStall = 0;
  string           mTag = "R1";
  string           pendTag = "";

  always @(posedge clk) begin
    if (!rstN) begin
      mPc = '0; mOutPc = '0; mBank = '0; mValid = 0; mStall = 0;
      mTag = "R1"; pendTag = "";
    end else begin
      if (jv) begin
        if (jk == 2'b00)      begin mPc = {mOutPc[PC_W-1:9], jd}; pendTag = "R6"; end
        else if (jk == 2'b01) begin mPc = {mBank[8:0], jd};       pendTag = "R7"; end
        else                  begin mPc = {js, jd};               pendTag = "R8"; end
        mValid = 0; mStall = 0; mTag = "R9";
      end else if (mPc < 512 || slotStb) begin
        mValid = 1; mStall = 0; mOutPc = mPc;
        mWord = (mPc < 512) ? locWord(mPc[8:0]) : shWord(mPc);
        if (pendTag != "")               mTag = pendTag;
        else if (mPc == 512 || mPc == 0) mTag = "R5";
        else                             mTag = (mPc < 512) ? "R2" : "R3";
        pendTag = "";
        mPc = mPc + 1'b1;
      end else begin
        mValid = 0; mStall = 1; mTag = "R4";
      end
      if (bw) mBank = {9'd0, bi};
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    chkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge, check strobes, then check outputs at the next falling edge
  task automatic step(input bit j, input logic [1:0] k, input logic [8:0] s, input logic [8:0] d,
                      input bit w, input logic [8:0] b);
    bit expL, expS;
    string sTag;
    jv = j; jk = k; js = s; jd = d; bw = w; bi = b;
    slotStb = ((cyc % SLOT_PERIOD) == PHASE);
    cyc++;
    #1;
    expL = !j && (mPc < 512);
    expS = !j && (mPc >= 512) && slotStb;
    sTag = (j && mPc >= 512 && slotStb) ? "R10" : (mTag == "R1" ? "R1" : "R3");
    chk(expL ? (mTag == "R1" ? "R1" : "R2") : "R9", "localRe", 64'(localRe), 64'(expL));
    chk(sTag, "sharedRe", 64'(sharedRe), 64'(expS));
    if (expL) chk("R2", "localAddr", 64'(localAddr), 64'(mPc[8:0]));
    if (expS) chk("R3", "sharedAddr", 64'(sharedAddr), 64'(mPc));
    if (sharedRe) chk("R11", "sharedAddr floor", 64'(sharedAddr >= 512), 64'd1);
    chk("R12", "single source", 64'(localRe && sharedRe), 64'd0);
    @(negedge clk);
    chk(mTag, "insnValid", 64'(insnValid), 64'(mValid));
    chk(mTag, "insnStall", 64'(insnStall), 64'(mStall));
    if (mValid) begin
      chk(mTag, "insnPc", 64'(insnPc), 64'(mOutPc));
      chk(mTag, "insnWord", 64'(insnWord), 64'(mWord));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 2'b00, 9'd0, 9'd0, 0, 9'd0);
  endtask

  initial begin
    #(8 * 150000);
    failCnt++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk("R1", "insnValid in reset", 64'(insnValid), 64'd0);
    chk("R1", "insnStall in reset", 64'(insnStall), 64'd0);
    rstN = 1'b1;
    idle(12);                                   // R2: local run from 0
    step(1, 2'b01, 9'd0, 9'd505, 0, 9'd0);      // R7: bank 0 -> 505
    idle(40);                                   // R5: 511 -> 512, R3/R4 shared waits
    step(0, 2'b00, 9'd0, 9'd0, 1, 9'd3);        // R7: load bank 3
    idle(1);
    step(1, 2'b01, 9'd0, 9'd7, 0, 9'd0);        // R7: -> 1543
    idle(20);
    step(1, 2'b00, 9'd0, 9'd100, 0, 9'd0);      // R6: near from bank 3 -> 1636
    idle(20);
    step(1, 2'b01, 9'd0, 9'd2, 1, 9'd9);        // R7: old bank 3 used -> 1538
    idle(18);
    step(1, 2'b01, 9'd0, 9'd0, 0, 9'd0);        // R7: new bank 9 -> 4608
    idle(18);
    step(1, 2'b10, 9'h1FF, 9'h1FE, 0, 9'd0);    // R8: -> top-1
    idle(30);                                   // R5: wrap to 0
    step(1, 2'b11, 9'd0, 9'd200, 0, 9'd0);      // R8: alternate long code -> 200
    idle(5);
    step(1, 2'b00, 9'd0, 9'd3, 0, 9'd0);        // R6: near in local space -> 3
    idle(4);
    step(1, 2'b10, 9'd2, 9'd0, 0, 9'd0);        // R8: -> 1024
    while ((cyc % SLOT_PERIOD) != PHASE) idle(1);
    step(1, 2'b10, 9'd0, 9'd40, 0, 9'd0);       // R10: jump on the strobe cycle
    idle(12);
    $display("End of test - %0d assertions evaluated, %0d failures", chkCnt, failCnt);
    $finish;
  end

endmodule